// File: doc/BRIEF.md
# NOR Flash Command State Machine

This block is a synthesizable front end for a parallel NOR flash storage array. A host talks to it over a simple synchronous bus that carries a byte address, write data, a write strobe with a transfer size, and a read strobe. The block decodes command words written to that bus and keeps track of a device mode. The mode decides what a read returns: array contents, identifier words, a geometry query table, or the status byte. The storage itself sits outside the block, behind a word-addressed memory port with a combinational read path.

Programming can only clear bits, because the new word is the old word ANDed with the written data. A block erase writes all-ones across one block, one word per cycle. While the erase runs, the ready bit reads 0 and further writes are ignored. Lock commands are accepted, but no protection is enforced. The data width is 8, 16 or 32 bits. Bus addresses are turned into word addresses by dropping the low address bits that select a byte within a word.

Top module: `nor_cmd_fsm`

## Requirements
- R1: After reset the block is in array-read mode, and a read returns the array word at the normalized word address (bus address shifted right by log2 of the bytes per word).
- R2: A write of 0xFF or 0xF0 returns the block to array-read mode from any mode. The exception is the one write taken as program data.
- R3: A write of 0x98 from array-read or identifier mode enters query mode only when the normalized word address is 0x55. At any other address the mode does not change.
- R4: In query mode, word offset 0x10..0x12 reads 0x51, 0x52, 0x59 and 0x13 reads 0x01. Offset 0x27 reads the log2 of the device size in bytes, and 0x2C reads 1. 0x2D/0x2E read the block count minus one (low byte, then high byte), and 0x2F/0x30 read the block size in bytes divided by 256 (low byte, then high byte). Every other offset reads 0.
- R5: A write of 0x90 from array-read or identifier mode enters identifier mode. There, word offset 0 reads 0x0089, 1 reads 0x00AD, 2 reads 0, 5 reads 0x8000, and every other offset reads 0.
- R6: A write of 0x40 or 0x10 from array-read or identifier mode arms programming. The next write stores old AND data at its word address, and the block then enters status mode. A read while programming is armed returns 0.
- R7: A write of 0x20 from array-read or identifier mode arms erase. A following 0xD0 erases the addressed block to all-ones and clears status bits 4 and 5. Any other value sets status bits 4 and 5 and erases nothing. In both cases the block enters status mode.
- R8: A write of 0x60 arms lock setup. A following 0x01, 0xD0 or 0x2F leaves the status unchanged, and any other value sets status bits 4 and 5. The block then enters status mode. A read while lock setup is armed returns 0.
- R9: The status byte resets to 0x80 (bit 7 = ready). A write of 0x50 in array-read or identifier mode sets it back to 0x80.
- R10: A read in status mode or in erase-armed mode returns the status byte in bits 7:0, with all higher data bits 0.
- R11: A write whose size in bytes differs from the configured word width changes neither the mode nor the array.
- R12: An erase occupies the memory port for exactly one cycle per block word. During that time status bit 7 reads 0 and every write is ignored.
- R13: An unrecognized command leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address |
| wrEn | input | 1 | Write strobe |
| wrSize | input | 3 | Bytes in this write (1, 2 or 4) |
| wrData | input | DATA_W | Write data; bits 7:0 carry commands |
| rdEn | input | 1 | Read strobe; read data is 0 when low |
| rdData | output | DATA_W | Combinational read data |
| memAddr | output | ADDR_W-log2(DATA_W/8) | Array word address |
| memWe | output | 1 | Array write enable |
| memWData | output | DATA_W | Array write data |
| memRData | input | DATA_W | Array read data, combinational from memAddr |

## Verification
The bench sweeps every array word and every query offset up to 0x3F, and checks each against values it computes itself. A wrong address shift or a shifted table entry would show up as a mismatch at one offset. The bench programs the same word twice, the second time with all-ones. A design that overwrites instead of ANDing would restore cleared bits. The erase test reads the words on both sides of the block boundary and checks that writes sent during the busy window are ignored. A design that erases the wrong span, or that acts on commands while busy, would break those reads or leave status mode early. The bench also checks the address rule for the query entry, wrong-size writes, the accepted and rejected lock and erase confirmations, and exits to array-read from every mode.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  typedef enum logic [2:0] {
    MD_ARRAY, MD_IDENT, MD_QUERY, MD_STATUS, MD_ERASE_ARM, MD_PROG_ARM, MD_LOCK_ARM
  } mode_t;

  typedef struct packed {
    logic progWr;
    logic eraseGo;
    logic stsClr;
    logic stsFail;
  } strobe_t;

  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_RD_RESET = 8'hF0;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_PROG_A   = 8'h40;
  localparam logic [7:0] CMD_PROG_B   = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_LOCK     = 8'h60;
  localparam logic [7:0] CMD_LK_SET   = 8'h01;
  localparam logic [7:0] CMD_LK_DOWN  = 8'h2F;
  localparam logic [7:0] CMD_STS_CLR  = 8'h50;
  localparam logic [7:0] QUERY_ADDR   = 8'h55;
endpackage

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import nor_cmd_pkg::*;
#(
  parameter int WADDR_W = 9,
  parameter int BYTES   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrSize,
  input  logic [7:0]         cmdByte,
  input  logic [WADDR_W-1:0] wordAddr,
  input  logic               eraseBusy,
  output mode_t              mode,
  output strobe_t            stb
);
  logic  wrOk;
  mode_t modeNext;

  assign wrOk = wrEn && (wrSize == 3'(BYTES)) && !eraseBusy;

  always_comb begin
    modeNext = mode;
    stb      = '0;
    if (wrOk) begin
      if (mode == MD_PROG_ARM) begin
        stb.progWr = 1'b1;
        modeNext   = MD_STATUS;
      end else if (cmdByte == CMD_RD_ARRAY || cmdByte == CMD_RD_RESET) begin
        modeNext = MD_ARRAY;
      end else begin
        case (mode)
          MD_ARRAY, MD_IDENT: begin
            case (cmdByte)
              CMD_QUERY:  if (wordAddr == WADDR_W'(QUERY_ADDR)) modeNext = MD_QUERY;
              CMD_IDENT:  modeNext = MD_IDENT;
              CMD_PROG_A, CMD_PROG_B: modeNext = MD_PROG_ARM;
              CMD_ERASE:  modeNext = MD_ERASE_ARM;
              CMD_LOCK:   modeNext = MD_LOCK_ARM;
              CMD_STS_CLR: stb.stsClr = 1'b1;
              default: ;
            endcase
          end
          MD_ERASE_ARM: begin
            if (cmdByte == CMD_CONFIRM) stb.eraseGo = 1'b1;
            else                        stb.stsFail = 1'b1;
            modeNext = MD_STATUS;
          end
          MD_LOCK_ARM: begin
            if (!(cmdByte == CMD_LK_SET || cmdByte == CMD_CONFIRM || cmdByte == CMD_LK_DOWN))
              stb.stsFail = 1'b1;
            modeNext = MD_STATUS;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mode <= MD_ARRAY;
    else       mode <= modeNext;
  end
endmodule

// File: rtl/nor_cmd_dp.sv
module nor_cmd_dp
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int BLK_WORDS = 128
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [ADDR_W-1:0]                     busAddr,
  input  logic [DATA_W-1:0]                     wrData,
  input  logic                                  rdEn,
  input  mode_t                                 mode,
  input  strobe_t                               stb,
  input  logic [DATA_W-1:0]                     memRData,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    wordAddr,
  output logic                                  eraseBusy,
  output logic [DATA_W-1:0]                     rdData,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]    memAddr,
  output logic                                  memWe,
  output logic [DATA_W-1:0]                     memWData
);
  localparam int BYTES     = DATA_W / 8;
  localparam int SHIFT     = $clog2(BYTES);
  localparam int WADDR_W   = ADDR_W - SHIFT;
  localparam int CNT_W     = $clog2(BLK_WORDS);
  localparam int BLK_IDX_W = WADDR_W - CNT_W;
  localparam int NUM_BLK   = (1 << WADDR_W) / BLK_WORDS;
  localparam int BLK_UNITS = (BLK_WORDS * BYTES) / 256;

  logic [7:0]           stsReg;
  logic [CNT_W-1:0]     eraseCnt;
  logic [BLK_IDX_W-1:0] eraseBlk;
  logic [31:0]          wa32;
  logic [31:0]          idVal;
  logic [31:0]          qVal;
  logic [7:0]           stsView;
  logic [DATA_W-1:0]    rdMux;

  assign wordAddr = busAddr[ADDR_W-1:SHIFT];
  assign wa32     = 32'(wordAddr);

  // status byte
  always_ff @(posedge clk) begin
    if (!rstN)            stsReg <= 8'h80;
    else if (stb.stsClr)  stsReg <= 8'h80;
    else if (stb.stsFail) stsReg <= stsReg | 8'h30;
    else if (stb.eraseGo) stsReg <= stsReg & 8'hCF;
  end
  assign stsView = {stsReg[7] & ~eraseBusy, stsReg[6:0]};

  // block erase sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      eraseBusy <= 1'b0;
      eraseCnt  <= '0;
      eraseBlk  <= '0;
    end else if (eraseBusy) begin
      eraseCnt <= eraseCnt + 1'b1;
      if (eraseCnt == CNT_W'(BLK_WORDS - 1)) eraseBusy <= 1'b0;
    end else if (stb.eraseGo) begin
      eraseBusy <= 1'b1;
      eraseCnt  <= '0;
      eraseBlk  <= wordAddr[WADDR_W-1:CNT_W];
    end
  end

  assign memAddr  = eraseBusy ? {eraseBlk, eraseCnt} : wordAddr;
  assign memWe    = eraseBusy | stb.progWr;
  assign memWData = eraseBusy ? '1 : (memRData & wrData);

  // identifier space
  always_comb begin
    case (wa32 & 32'h1FF)
      32'h0:   idVal = 32'h0089;
      32'h1:   idVal = 32'h00AD;
      32'h5:   idVal = 32'h8000;
      default: idVal = 32'h0;
    endcase
  end

  // geometry query table
  always_comb begin
    case (wa32)
      32'h10:  qVal = 32'h51;
      32'h11:  qVal = 32'h52;
      32'h12:  qVal = 32'h59;
      32'h13:  qVal = 32'h01;
      32'h27:  qVal = 32'(ADDR_W);
      32'h2C:  qVal = 32'h01;
      32'h2D:  qVal = 32'((NUM_BLK - 1) & 255);
      32'h2E:  qVal = 32'(((NUM_BLK - 1) >> 8) & 255);
      32'h2F:  qVal = 32'(BLK_UNITS & 255);
      32'h30:  qVal = 32'((BLK_UNITS >> 8) & 255);
      default: qVal = 32'h0;
    endcase
  end

  always_comb begin
    case (mode)
      MD_ARRAY:                rdMux = memRData;
      MD_IDENT:                rdMux = DATA_W'(idVal);
      MD_QUERY:                rdMux = DATA_W'(qVal);
      MD_STATUS, MD_ERASE_ARM: rdMux = DATA_W'(32'(stsView));
      default:                 rdMux = '0;
    endcase
  end
  assign rdData = rdEn ? rdMux : '0;
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 16,
  parameter int BLK_WORDS = 128
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic                               wrEn,
  input  logic [2:0]                         wrSize,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic                               rdEn,
  output logic [DATA_W-1:0]                  rdData,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] memAddr,
  output logic                               memWe,
  output logic [DATA_W-1:0]                  memWData,
  input  logic [DATA_W-1:0]                  memRData
);
  localparam int BYTES   = DATA_W / 8;
  localparam int WADDR_W = ADDR_W - $clog2(BYTES);

  mode_t              curMode;
  strobe_t            stb;
  logic               eraseBusy;
  logic [WADDR_W-1:0] wordAddr;

  nor_cmd_ctrl #(.WADDR_W(WADDR_W), .BYTES(BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSize(wrSize), .cmdByte(wrData[7:0]),
    .wordAddr(wordAddr), .eraseBusy(eraseBusy), .mode(curMode), .stb(stb)
  );

  nor_cmd_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrData(wrData), .rdEn(rdEn),
    .mode(curMode), .stb(stb), .memRData(memRData), .wordAddr(wordAddr),
    .eraseBusy(eraseBusy), .rdData(rdData), .memAddr(memAddr), .memWe(memWe),
    .memWData(memWData)
  );
endmodule

// File: rtl/nor_cmd_fsm_chk.sv
module nor_cmd_fsm_chk
  import nor_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrSize,
  input logic [DATA_W-1:0] wrData,
  input logic              memWe,
  input logic [DATA_W-1:0] memWData,
  input logic [DATA_W-1:0] memRData,
  input logic              eraseBusy,
  input mode_t             curMode
);
  localparam int BYTES = DATA_W / 8;

  // R6
  prog_clears_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !eraseBusy) |-> ((memWData & ~memRData) == '0));

  // R2
  exit_to_array_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize == 3'(BYTES) && !eraseBusy && curMode != MD_PROG_ARM &&
     (wrData[7:0] == 8'hFF || wrData[7:0] == 8'hF0)) |=> (curMode == MD_ARRAY));

  // R12
  busy_ignores_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |=> $stable(curMode));

  // R12
  busy_in_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |-> (curMode == MD_STATUS && memWe));

  // R11
  bad_size_no_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSize != 3'(BYTES)) |=> $stable(curMode));

  // R11
  bad_size_no_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrSize != 3'(BYTES) && !eraseBusy) |-> !memWe);
endmodule

bind nor_cmd_fsm nor_cmd_fsm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSize(wrSize), .wrData(wrData),
  .memWe(memWe), .memWData(memWData), .memRData(memRData),
  .eraseBusy(eraseBusy), .curMode(curMode)
);

// File: tb/nor_cmd_fsm_tb.sv
module nor_cmd_fsm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 16;
  localparam int BLK_WORDS = 128;
  localparam int WORDS = 512;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              wrEn = 1'b0;
  logic [2:0]        wrSize = 3'd2;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdEn = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic [8:0]        memAddr;
  logic              memWe;
  logic [DATA_W-1:0] memWData;
  logic [DATA_W-1:0] memRData;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] expMem [WORDS];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign memRData = mem[memAddr];
  always @(posedge clk) if (memWe) mem[memAddr] <= memWData;

  nor_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_WORDS(BLK_WORDS)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrSize(wrSize),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .memAddr(memAddr),
    .memWe(memWe), .memWData(memWData), .memRData(memRData)
  );

  function automatic logic [15:0] pat(int i);
    return 16'(i * 16'h9E37 + 16'h5A3C);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int word, logic [15:0] d, logic [2:0] sz = 3'd2);
    @(negedge clk);
    busAddr = ADDR_W'(word * 2);
    wrData = d;
    wrSize = sz;
    wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rd(int word, output logic [15:0] v);
    @(negedge clk);
    busAddr = ADDR_W'(word * 2);
    rdEn = 1'b1;
    #1 v = rdData;
    rdEn = 1'b0;
  endtask

  function automatic logic [15:0] qExp(int off);
    case (off)
      16'h10: return 16'h51;
      16'h11: return 16'h52;
      16'h12: return 16'h59;
      16'h13: return 16'h01;
      16'h27: return 16'(ADDR_W);
      16'h2C: return 16'h01;
      16'h2D: return 16'((WORDS / BLK_WORDS) - 1);
      16'h2F: return 16'((BLK_WORDS * 2) / 256);
      default: return 16'h0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = pat(i);
      expMem[i] = pat(i);
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 array sweep after reset
    for (int i = 0; i < WORDS; i++) begin
      rd(i, v);
      chk("R1 array read", v, expMem[i]);
    end

    // R3 query only at word 0x55
    wr(16'h54, 16'h98);
    rd(16'h10, v);
    chk("R3 wrong query addr", v, expMem[16'h10]);
    wr(16'h55, 16'h98);
    for (int off = 0; off < 64; off++) begin
      rd(off, v);
      chk("R4 query table", v, qExp(off));
    end
    wr(0, 16'hF0);
    rd(3, v);
    chk("R2 F0 from query", v, expMem[3]);

    // R5 identifier
    wr(7, 16'h90);
    for (int off = 0; off < 8; off++) begin
      rd(off, v);
      chk("R5 ident", v, off == 0 ? 16'h0089 : off == 1 ? 16'h00AD : off == 5 ? 16'h8000 : 16'h0);
    end
    // R13 unknown command in ident mode
    wr(0, 16'h77);
    rd(1, v);
    chk("R13 unknown keeps ident", v, 16'h00AD);
    // R3 query also from ident mode
    wr(16'h55, 16'h98);
    rd(16'h11, v);
    chk("R3 query from ident", v, 16'h52);
    wr(0, 16'hFF);
    rd(9, v);
    chk("R2 FF from query", v, expMem[9]);

    // R13 unknown in array mode
    wr(0, 16'h77);
    rd(4, v);
    chk("R13 unknown keeps array", v, expMem[4]);

    // R11 wrong size write ignored
    wr(0, 16'h90, 3'd1);
    rd(0, v);
    chk("R11 byte-size cmd ignored", v, expMem[0]);

    // R6 program
    wr(16'h40, 16'h40);
    rd(16'h40, v);
    chk("R6 read in prog-armed", v, 16'h0);
    wr(16'h40, 16'h0000, 3'd4);
    rd(16'h40, v);
    chk("R11 wrong size data ignored", v, 16'h0);
    wr(16'h40, 16'h0F0F);
    expMem[16'h40] = expMem[16'h40] & 16'h0F0F;
    rd(16'h40, v);
    chk("R10 status after program", v, 16'h0080);
    wr(0, 16'hFF);
    rd(16'h40, v);
    chk("R6 AND program", v, expMem[16'h40]);
    wr(16'h40, 16'h10);
    wr(16'h40, 16'hFFFF);
    wr(0, 16'hFF);
    rd(16'h40, v);
    chk("R6 cannot set bits", v, expMem[16'h40]);
    // program data equal to FF is data, not a command
    wr(16'h41, 16'h40);
    wr(16'h41, 16'h00FF);
    expMem[16'h41] = expMem[16'h41] & 16'h00FF;
    rd(16'h41, v);
    chk("R2 FF as program data", v, 16'h0080);
    wr(0, 16'hFF);
    rd(16'h41, v);
    chk("R6 FF data stored", v, expMem[16'h41]);

    // R7 bad erase confirm
    wr(130, 16'h20);
    wr(130, 16'h33);
    rd(0, v);
    chk("R7 bad confirm status", v, 16'h00B0);
    wr(0, 16'hFF);
    rd(130, v);
    chk("R7 bad confirm no erase", v, expMem[130]);
    // R9 clear, R10 status in erase-armed
    wr(0, 16'h50);
    wr(0, 16'h20);
    rd(0, v);
    chk("R9 clear to 0x80 / R10 erase-armed read", v, 16'h0080);
    wr(0, 16'hF0);
    rd(0, v);
    chk("R2 F0 from erase-armed", v, expMem[0]);

    // R8 lock setup
    wr(0, 16'h60);
    rd(0, v);
    chk("R8 read in lock-armed", v, 16'h0);
    wr(0, 16'h2F);
    rd(0, v);
    chk("R8 accepted lock", v, 16'h0080);
    wr(0, 16'hFF);
    wr(0, 16'h60);
    wr(0, 16'h01);
    rd(0, v);
    chk("R8 accepted lock 01", v, 16'h0080);
    wr(0, 16'hFF);
    wr(0, 16'h60);
    wr(0, 16'h55);
    rd(0, v);
    chk("R8 rejected lock", v, 16'h00B0);
    wr(0, 16'hFF);
    wr(0, 16'h50);

    // R7 / R12 good erase of block 1
    wr(130, 16'h20);
    wr(130, 16'hD0);
    for (int i = 128; i < 256; i++) expMem[i] = 16'hFFFF;
    rd(0, v);
    chk("R12 ready low while busy", v, 16'h0000);
    wr(0, 16'hFF);
    wr(0, 16'h40);
    rd(0, v);
    chk("R12 writes ignored while busy", v, 16'h0000);
    repeat (BLK_WORDS + 4) @(posedge clk);
    rd(0, v);
    chk("R12 ready after erase", v, 16'h0080);
    wr(0, 16'hFF);
    for (int i = 0; i < WORDS; i++) begin
      rd(i, v);
      chk("R7 array after erase", v, expMem[i]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule